// File: doc/BRIEF.md
# Eight-Slot TDM Audio Serial Port (Follower Side)

This block is the processor-side endpoint of a time-division-multiplexed audio link. The external codec owns the timing and supplies the bit clock and the frame sync. The block only follows them. Each frame is 256 bit periods long, split into eight 32-bit slots. The frame rate equals the audio sample rate, so every slot carries one sample per frame in each direction.

The block samples the bit clock, frame sync and serial input with its own fast system clock, using a short synchronizer chain. Edge detection then turns them into bit-period events.

- **Receive:** on each falling bit-clock edge the block captures one bit, most significant first. When the last bit of a slot arrives, it presents the whole word with its slot index and a one-cycle strobe.
- **Transmit:** on each rising bit-clock edge the block advances the serial output. The words come from an eight-entry staging bank that the system loads ahead of time. If no word is staged when a slot starts, that slot goes out as zeros and an underrun flag is raised.
- **Alignment:** slot alignment follows the frame sync rising edge. A frame sync edge that comes at the wrong count sets an error flag, and the bit position is realigned to that edge.

Top module: `tdm_slave_port`

## Requirements
- R1: After reset, `rx_valid_o`, `sdout_o`, `stat_fsync_err_o` and `stat_underrun_o` are all 0.
- R2: Serial input is captured on falling bit-clock edges, most significant bit first. Bit 31 of slot 0 is the bit captured at the falling edge where the frame sync is first seen high after being low. Slot k then occupies frame bits 32k to 32k+31.
- R3: After the last bit of each slot is captured, `rx_valid_o` is high for exactly one system clock cycle. In that cycle `rx_word_o` holds the slot's 32-bit word and `rx_slot_o` holds the slot index 0 to 7. Slots are delivered in ascending order within a frame.
- R4: Until the first frame sync rising edge is seen, no receive word is delivered.
- R5: Serial output changes only after rising bit-clock edges, so it is stable at the falling edge. Slot s of a frame carries the word staged for slot s, most significant bit first.
- R6: `sdout_o` stays 0 before lock and during the first frame after lock. Transmission starts with slot 0 of the second frame.
- R7: Writing `tx_wr_word_i` with `tx_wr_i` high stages the word for slot `tx_wr_slot_i`. Each staged word is used once. If a slot starts with nothing staged, that slot is sent as 32 zeros and `stat_underrun_o` goes to 1 and stays there.
- R8: A frame sync rising edge seen after any count other than 256 bit periods since the previous one sets `stat_fsync_err_o`, which stays set. The first edge after reset and edges 256 bits apart never set it.
- R9: After a misplaced frame sync edge, the bit position restarts at that edge. The following frame's receive slots are correctly aligned.
- R10: A high `stat_clr_i` clears both status flags on the next cycle. The clear takes priority over a new error in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bit clock from the codec |
| fsync_i | input | 1 | Frame sync from the codec |
| sdin_i | input | 1 | Serial data from the codec |
| sdout_o | output | 1 | Serial data to the codec |
| rx_valid_o | output | 1 | One-cycle strobe for a received word |
| rx_slot_o | output | 3 | Slot index of the received word |
| rx_word_o | output | 32 | Received slot word |
| tx_wr_i | input | 1 | Stage a transmit word |
| tx_wr_slot_i | input | 3 | Slot that the staged word is for |
| tx_wr_word_i | input | 32 | Transmit word to stage |
| stat_clr_i | input | 1 | Clear both status flags |
| stat_fsync_err_o | output | 1 | Sticky frame-sync placement error |
| stat_underrun_o | output | 1 | Sticky transmit underrun |

## Verification
The assertions take three things for granted about the inputs:
- each high and low phase of the bit clock lasts more system cycles than the synchronizer depth plus one, so two bit events never fall in adjacent cycles;
- the frame sync and serial input change only together with a rising bit-clock edge;
- `stat_clr_i` is a short pulse.

The bench models the codec with six system cycles per bit-clock phase. It changes `fsync_i` and `sdin_i` only in the cycle where it raises `bclk_i`, and it pulses the clear for a single cycle while the bit clock is high. Against that stimulus the strobe-width, quiet-output and sticky-flag properties follow.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
   parameter int unsigned TDM_SLOTS_DEF  = 8;
   parameter int unsigned TDM_SLOT_W_DEF = 32;
   parameter int unsigned TDM_SYNC_DEF   = 2;

   typedef struct packed {
      logic fsync_err;
      logic underrun;
   } tdm_stat_t;
endpackage

// File: rtl/tdm_sync.sv
module tdm_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[i] <= '0;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tdm_frame_track.sv
module tdm_frame_track #(
   parameter int unsigned FRAME_BITS = 256,
   parameter int unsigned CNT_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_s,
   input  logic             fs_s,
   output logic             rise_evt,
   output logic             take,
   output logic [CNT_W-1:0] bit_pos,
   output logic [CNT_W-1:0] cnt,
   output logic             locked,
   output logic             tx_active,
   output logic             fs_err_evt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

   logic bclk_q, fs_prev, fall_evt, fs_edge;

   assign rise_evt = bclk_s & ~bclk_q;
   assign fall_evt = ~bclk_s & bclk_q;
   assign fs_edge  = fall_evt & fs_s & ~fs_prev;
   assign bit_pos  = fs_edge ? '0 : cnt + CNT_W'(1);
   assign take     = fall_evt & (locked | fs_edge);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_q     <= 1'b0;
         fs_prev    <= 1'b0;
         cnt        <= '0;
         locked     <= 1'b0;
         tx_active  <= 1'b0;
         fs_err_evt <= 1'b0;
      end else begin
         bclk_q     <= bclk_s;
         fs_err_evt <= 1'b0;
         if (fall_evt) begin
            fs_prev <= fs_s;
            if (locked || fs_edge) cnt <= bit_pos;
            if (fs_edge) begin
               locked <= 1'b1;
               if (locked && cnt != LAST) fs_err_evt <= 1'b1;
            end
            if (locked && !fs_edge && bit_pos == LAST) tx_active <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
   parameter int unsigned SLOT_W     = 32,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned SLOT_IDX_W = 3,
   parameter int unsigned BIT_IDX_W  = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take,
   input  logic [CNT_W-1:0]      bit_pos,
   input  logic                  sdin,
   output logic                  rx_valid,
   output logic [SLOT_IDX_W-1:0] rx_slot,
   output logic [SLOT_W-1:0]     rx_word
);
   localparam logic [BIT_IDX_W-1:0] END_BIT = BIT_IDX_W'(SLOT_W - 1);

   logic [SLOT_W-1:0] shreg, shnext;
   assign shnext = {shreg[SLOT_W-2:0], sdin};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg    <= '0;
         rx_valid <= 1'b0;
         rx_slot  <= '0;
         rx_word  <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (take) begin
            shreg <= shnext;
            if (bit_pos[BIT_IDX_W-1:0] == END_BIT) begin
               rx_valid <= 1'b1;
               rx_word  <= shnext;
               rx_slot  <= bit_pos[CNT_W-1 -: SLOT_IDX_W];
            end
         end
      end
   end
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
   parameter int unsigned SLOTS      = 8,
   parameter int unsigned SLOT_W     = 32,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned SLOT_IDX_W = 3,
   parameter int unsigned BIT_IDX_W  = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rise_evt,
   input  logic                  tx_active,
   input  logic [CNT_W-1:0]      cnt,
   input  logic                  wr,
   input  logic [SLOT_IDX_W-1:0] wr_slot,
   input  logic [SLOT_W-1:0]     wr_word,
   output logic                  sdout,
   output logic                  uf_evt
);
   logic [SLOT_W-1:0]     stage [SLOTS];
   logic [SLOTS-1:0]      full;
   logic [SLOT_W-1:0]     shreg, load_word;
   logic [CNT_W-1:0]      pos_pred;
   logic [SLOT_IDX_W-1:0] cur_slot;
   logic                  step, slot_start;

   assign pos_pred   = cnt + CNT_W'(1);
   assign cur_slot   = pos_pred[CNT_W-1 -: SLOT_IDX_W];
   assign step       = rise_evt & tx_active;
   assign slot_start = step & (pos_pred[BIT_IDX_W-1:0] == '0);
   assign load_word  = full[cur_slot] ? stage[cur_slot] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) stage[i] <= '0;
         full   <= '0;
         shreg  <= '0;
         sdout  <= 1'b0;
         uf_evt <= 1'b0;
      end else begin
         uf_evt <= 1'b0;
         if (slot_start) begin
            sdout          <= load_word[SLOT_W-1];
            shreg          <= {load_word[SLOT_W-2:0], 1'b0};
            uf_evt         <= ~full[cur_slot];
            full[cur_slot] <= 1'b0;
         end else if (step) begin
            sdout <= shreg[SLOT_W-1];
            shreg <= {shreg[SLOT_W-2:0], 1'b0};
         end
         if (wr) begin
            stage[wr_slot] <= wr_word;
            full[wr_slot]  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/tdm_slave_port.sv
module tdm_slave_port
   import tdm_port_pkg::*;
#(
   parameter int unsigned SLOTS       = TDM_SLOTS_DEF,
   parameter int unsigned SLOT_W      = TDM_SLOT_W_DEF,
   parameter int unsigned SYNC_STAGES = TDM_SYNC_DEF,
   localparam int unsigned SLOT_IDX_W = $clog2(SLOTS),
   localparam int unsigned BIT_IDX_W  = $clog2(SLOT_W),
   localparam int unsigned FRAME_BITS = SLOTS * SLOT_W,
   localparam int unsigned CNT_W      = $clog2(FRAME_BITS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bclk_i,
   input  logic                  fsync_i,
   input  logic                  sdin_i,
   output logic                  sdout_o,
   output logic                  rx_valid_o,
   output logic [SLOT_IDX_W-1:0] rx_slot_o,
   output logic [SLOT_W-1:0]     rx_word_o,
   input  logic                  tx_wr_i,
   input  logic [SLOT_IDX_W-1:0] tx_wr_slot_i,
   input  logic [SLOT_W-1:0]     tx_wr_word_i,
   input  logic                  stat_clr_i,
   output logic                  stat_fsync_err_o,
   output logic                  stat_underrun_o
);
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two, at least 2");
   end
   if (SLOT_W < 2 || (SLOT_W & (SLOT_W - 1)) != 0) begin : g_bad_width
      $error("SLOT_W must be a power of two, at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             bclk_s, fs_s, sdin_s;
   logic             rise_evt, take, locked, tx_active, fs_err_evt, uf_evt;
   logic [CNT_W-1:0] bit_pos, cnt;
   tdm_stat_t        stat;

   tdm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({bclk_i, fsync_i, sdin_i}),
      .q({bclk_s, fs_s, sdin_s})
   );

   tdm_frame_track #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_track (
      .clk(clk), .rst_n(rst_n), .bclk_s(bclk_s), .fs_s(fs_s),
      .rise_evt(rise_evt), .take(take), .bit_pos(bit_pos), .cnt(cnt),
      .locked(locked), .tx_active(tx_active), .fs_err_evt(fs_err_evt)
   );

   tdm_rx_deser #(.SLOT_W(SLOT_W), .CNT_W(CNT_W), .SLOT_IDX_W(SLOT_IDX_W),
                  .BIT_IDX_W(BIT_IDX_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .take(take), .bit_pos(bit_pos), .sdin(sdin_s),
      .rx_valid(rx_valid_o), .rx_slot(rx_slot_o), .rx_word(rx_word_o)
   );

   tdm_tx_ser #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W),
                .SLOT_IDX_W(SLOT_IDX_W), .BIT_IDX_W(BIT_IDX_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .tx_active(tx_active),
      .cnt(cnt), .wr(tx_wr_i), .wr_slot(tx_wr_slot_i), .wr_word(tx_wr_word_i),
      .sdout(sdout_o), .uf_evt(uf_evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat <= '0;
      end else if (stat_clr_i) begin
         stat <= '0;
      end else begin
         stat.fsync_err <= stat.fsync_err | fs_err_evt;
         stat.underrun  <= stat.underrun | uf_evt;
      end
   end

   assign stat_fsync_err_o = stat.fsync_err;
   assign stat_underrun_o  = stat.underrun;
endmodule

// File: rtl/tdm_slave_port_chk.sv
module tdm_slave_port_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_valid,
   input logic sdout,
   input logic locked,
   input logic tx_active,
   input logic clr,
   input logic fs_err,
   input logic underrun
);
   // R3: the receive strobe lasts one cycle
   a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R4: nothing is delivered before the first frame sync edge
   a_r4_no_rx_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !rx_valid);

   // R6: the serial output stays low until transmission is enabled
   a_r6_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_active |-> !sdout);

   // R8: the frame sync error flag is sticky
   a_r8_fs_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_err && !clr) |=> fs_err);

   // R7: the underrun flag is sticky
   a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !clr) |=> underrun);

   // R10: a clear empties both flags
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!fs_err && !underrun));
endmodule

bind tdm_slave_port tdm_slave_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid_o), .sdout(sdout_o),
   .locked(locked), .tx_active(tx_active), .clr(stat_clr_i),
   .fs_err(stat_fsync_err_o), .underrun(stat_underrun_o)
);

// File: tb/tdm_slave_port_test.sv
module tdm_slave_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0, fsync = 1'b0, sdin = 1'b0;
   logic        sdout, rx_valid, tx_wr = 1'b0, stat_clr = 1'b0;
   logic [2:0]  rx_slot, tx_wr_slot = '0;
   logic [31:0] rx_word, tx_wr_word = '0;
   logic        st_fs, st_uf;

   int n_checks = 0;
   int n_err    = 0;
   int rx_total = 0;
   int frame_base = 0;
   int cur_f = -1;
   bit finished = 0;

   always #2 clk = ~clk;

   tdm_slave_port uut (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdin_i(sdin),
      .sdout_o(sdout), .rx_valid_o(rx_valid), .rx_slot_o(rx_slot),
      .rx_word_o(rx_word), .tx_wr_i(tx_wr), .tx_wr_slot_i(tx_wr_slot),
      .tx_wr_word_i(tx_wr_word), .stat_clr_i(stat_clr),
      .stat_fsync_err_o(st_fs), .stat_underrun_o(st_uf)
   );

   function automatic logic [31:0] rx_pat(input int f, input int s);
      return 32'h9A3C0000 ^ (f * 32'h01030507) ^ (s * 32'h10204081);
   endfunction

   function automatic logic [31:0] tx_pat(input int f, input int s);
      return ~rx_pat(f, s) + 32'(s * 3 + 1);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   endtask

   // receive monitor (R2, R3)
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         chk(rx_slot == 3'(rx_total - frame_base), "R3 slot index",
             32'(rx_slot), 32'(rx_total - frame_base));
         chk(rx_word == rx_pat(cur_f, rx_total - frame_base), "R2 rx word",
             rx_word, rx_pat(cur_f, rx_total - frame_base));
         rx_total++;
      end
   end

   // one bit period: 6 cycles high, 6 cycles low; tx sampled at falling edge
   task automatic run_bit(input logic fs_v, input logic d_v, input logic wr_v,
                          input int wr_s, input logic [31:0] wr_d,
                          input logic clr_v, output logic txb);
      @(negedge clk);
      bclk = 1'b1; fsync = fs_v; sdin = d_v;
      tx_wr = wr_v; tx_wr_slot = 3'(wr_s); tx_wr_word = wr_d; stat_clr = clr_v;
      @(negedge clk);
      tx_wr = 1'b0; stat_clr = 1'b0;
      repeat (4) @(negedge clk);
      @(negedge clk);
      bclk = 1'b0; txb = sdout;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic txb;
      logic [31:0] cap;
      logic pre_tx_any;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(rx_valid == 0 && sdout == 0, "R1 reset outputs", {rx_valid, sdout}, 0);
      chk(st_fs == 0 && st_uf == 0, "R1 reset flags", {st_fs, st_uf}, 0);

      // before lock: data toggles, frame sync idle (R4)
      pre_tx_any = 1'b0;
      for (int b = 0; b < 40; b++) begin
         run_bit(1'b0, b[0], 1'b0, 0, 0, 1'b0, txb);
         pre_tx_any |= txb;
      end
      chk(rx_total == 0, "R4 no rx before lock", rx_total, 0);
      chk(pre_tx_any == 0, "R4 tx idle before lock", pre_tx_any, 0);

      for (int f = 0; f < 10; f++) begin
         int len;
         len = (f == 6) ? 200 : 256;
         cur_f = f;
         frame_base = rx_total;
         cap = '0;
         for (int b = 0; b < len; b++) begin
            int s, k;
            logic wr_v, clr_v;
            logic [31:0] exp;
            s = b / 32; k = b % 32;
            wr_v  = (k == 16) && !(f == 3 && s == 3);
            clr_v = (k == 4 && s == 0) && (f == 5 || f == 8);
            run_bit(b == 0, rx_pat(f, s)[31-k], wr_v, s, tx_pat(f + 1, s),
                    clr_v, txb);
            cap = {cap[30:0], txb};
            if (k == 31 && f != 6 && f != 7) begin
               if (f == 0) begin
                  exp = '0;
                  chk(cap == exp, "R6 first frame silent", cap, exp);
               end else if (f == 4 && s == 3) begin
                  exp = '0;
                  chk(cap == exp, "R7 underrun slot zero", cap, exp);
               end else begin
                  exp = tx_pat(f, s);
                  chk(cap == exp, "R5 tx word", cap, exp);
               end
            end
            if (f == 7 && b == 8)
               chk(st_fs == 1, "R8 misplaced edge flagged", st_fs, 1);
         end
         chk(rx_total - frame_base == ((f == 6) ? 6 : 8), "R3 words per frame",
             rx_total - frame_base, (f == 6) ? 6 : 8);
         case (f)
            0: chk(st_fs == 0, "R8 no error on first edge", st_fs, 0);
            3: chk(st_uf == 0, "R7 no underrun while staged", st_uf, 0);
            4: chk(st_uf == 1, "R7 underrun flag set", st_uf, 1);
            5: begin
               chk(st_uf == 0, "R10 underrun cleared", st_uf, 0);
               chk(st_fs == 0, "R8 no error on regular frames", st_fs, 0);
            end
            7: chk(rx_total - frame_base == 8, "R9 realigned frame", rx_total - frame_base, 8);
            default: ;
         endcase
      end
      chk(st_fs == 0 && st_uf == 0, "R10 both flags cleared", {st_fs, st_uf}, 0);
      summary();
   end
endmodule